// File: doc/BRIEF.md
# Operand Stack with Register-Cached Top Pair

This block is the operand-stack datapath of a small stack processor. The two most recent stack entries are kept in registers, the top (`tos`) and the one below it (`nos`). Every older entry sits in a synchronous RAM that has one write port and one separate read port. Both registers feed the ALU directly, so no operand of a binary operation has to come from memory. That lets every command finish in a single clock cycle.

Each cycle the block takes one 3-bit command. A push spills the old `nos` into RAM, shifts the old top down into `nos` and loads the literal as the new top. A pop or a binary operation consumes the top pair and refills `nos` from the newest RAM entry. To hide the read latency, the RAM read port is always addressed with the slot that will be the newest entry after the current edge. A same-cycle write to that slot is forwarded to the read data. The block also tracks how many entries the whole stack holds, and it rejects commands that would overflow or underflow. Rejections are recorded in sticky flags.

Top module: `tos_cache_stack`

## Requirements
- R1: A synchronous active-high reset sets `tos`, `nos` and `depth` to zero and clears both flags.
- R2: Command 3'b001 (push) with `depth` below RAM_DEPTH+2 completes in one cycle: `tos` takes `lit`, `nos` takes the previous `tos`, and `depth` rises by one.
- R3: Commands 3'b011 add, 3'b100 sub, 3'b101 and, 3'b110 or, 3'b111 xor with `depth` of at least 2 complete in one cycle. `tos` takes `nos` op `tos` (sub gives `nos` minus `tos`, modulo 2^DATA_W), and `depth` falls by one.
- R4: When a pop or binary operation starts with `depth` of at least 3, the new `nos` is the most recently spilled value that has not been refilled yet (last in, first out).
- R5: Command 3'b010 (pop) with `depth` of at least 1 completes in one cycle: `tos` takes the previous `nos`, and `depth` falls by one. No ALU operation is applied.
- R6: Any register position that holds no stack entry reads as zero. `nos` is zero when `depth` is below 2, and `tos` is zero when `depth` is 0.
- R7: Command 3'b000 (nop) leaves `tos`, `nos`, `depth` and both flags unchanged.
- R8: A push at `depth` equal to RAM_DEPTH+2 sets `overflow`, which stays set until reset. `tos`, `nos` and `depth` are left unchanged.
- R9: A pop at `depth` 0, or a binary operation at `depth` below 2, sets `underflow`, which stays set until reset. `tos`, `nos` and `depth` are left unchanged.
- R10: A pop or binary operation in the cycle right after a push that spilled to RAM refills `nos` with the value that push just spilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code for this cycle |
| lit | input | DATA_W | Literal used by push |
| tos | output | DATA_W | Top stack entry |
| nos | output | DATA_W | Second stack entry |
| depth | output | $clog2(RAM_DEPTH+3) | Number of entries in registers and RAM |
| overflow | output | 1 | Sticky: a push was refused on a full stack |
| underflow | output | 1 | Sticky: a pop or operation was refused for lack of entries |

## Verification
A wrong stack pointer or a refill read from a stale RAM slot shows up in `nos` on the very next cycle after a pop or operation that begins with three or more entries. If it is missed there, it appears in `tos` one consuming command later. A missing write-to-read forward is exposed only by a consume that directly follows a spilling push, so those pairs are driven back to back. A wrong depth count first shows as a flag raised on an edge where it should not be, or not raised at the exact full and empty limits. Because of this, the full stack is filled to its limit and then drained completely, and every popped value is compared.

// File: rtl/tos_pkg.sv
package tos_pkg;

   typedef enum logic [2:0] {
      OP_NOP  = 3'b000,
      OP_PUSH = 3'b001,
      OP_POP  = 3'b010,
      OP_ADD  = 3'b011,
      OP_SUB  = 3'b100,
      OP_AND  = 3'b101,
      OP_OR   = 3'b110,
      OP_XOR  = 3'b111
   } stk_op_e;

   function automatic logic is_binary(stk_op_e op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
             (op == OP_OR)  || (op == OP_XOR);
   endfunction

endpackage

// File: rtl/tos_stack_ram.sv
module tos_stack_ram #(
   parameter int WIDTH = 32,
   parameter int SLOTS = 64,
   localparam int AW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);

   logic [WIDTH-1:0] cells [SLOTS];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         cells[wr_addr] <= wr_data;
      end
   end

   // registered read; a write to the addressed slot in the same cycle is forwarded
   always_ff @(posedge clk) begin
      if (rst) begin
         rd_data <= '0;
      end else if (wr_en && (wr_addr == rd_addr)) begin
         rd_data <= wr_data;
      end else begin
         rd_data <= cells[rd_addr];
      end
   end

endmodule

// File: rtl/tos_alu.sv
module tos_alu
   import tos_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  stk_op_e          op,
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      unique case (op)
         OP_ADD:  res = lhs + rhs;
         OP_SUB:  res = lhs - rhs;
         OP_AND:  res = lhs & rhs;
         OP_OR:   res = lhs | rhs;
         OP_XOR:  res = lhs ^ rhs;
         default: res = rhs;
      endcase
   end

endmodule

// File: rtl/tos_depth_ctrl.sv
module tos_depth_ctrl
   import tos_pkg::*;
#(
   parameter int CAP = 66,
   localparam int DW = $clog2(CAP + 1)
) (
   input  stk_op_e       op,
   input  logic [DW-1:0] depth_q,
   output logic          accept,
   output logic          spill,
   output logic          refill,
   output logic          ovf_hit,
   output logic          udf_hit,
   output logic [DW-1:0] depth_d
);

   localparam logic [DW-1:0] FULL = DW'(CAP);
   localparam logic [DW-1:0] ONE  = DW'(1);
   localparam logic [DW-1:0] TWO  = DW'(2);
   localparam logic [DW-1:0] THREE = DW'(3);

   logic is_push, is_pop, is_bin;

   always_comb begin
      is_push = (op == OP_PUSH);
      is_pop  = (op == OP_POP);
      is_bin  = is_binary(op);

      ovf_hit = is_push && (depth_q == FULL);
      udf_hit = (is_pop && (depth_q < ONE)) || (is_bin && (depth_q < TWO));
      accept  = !ovf_hit && !udf_hit && (op != OP_NOP);

      spill   = accept && is_push && (depth_q >= TWO);
      refill  = accept && (is_pop || is_bin) && (depth_q >= THREE);

      depth_d = depth_q;
      if (accept && is_push) begin
         depth_d = depth_q + ONE;
      end else if (accept) begin
         depth_d = depth_q - ONE;
      end
   end

endmodule

// File: rtl/tos_cache_stack.sv
module tos_cache_stack
   import tos_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int RAM_DEPTH = 64,
   localparam int CAP = RAM_DEPTH + 2,
   localparam int DW  = $clog2(CAP + 1),
   localparam int AW  = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        cmd,
   input  logic [DATA_W-1:0] lit,
   output logic [DATA_W-1:0] tos,
   output logic [DATA_W-1:0] nos,
   output logic [DW-1:0]     depth,
   output logic              overflow,
   output logic              underflow
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("tos_cache_stack: DATA_W must be at least 1");
      end
      if (RAM_DEPTH < 2) begin : g_bad_depth
         $error("tos_cache_stack: RAM_DEPTH must be at least 2");
      end
   endgenerate

   stk_op_e op;
   assign op = stk_op_e'(cmd);

   logic [DATA_W-1:0] a_q, b_q, alu_res, refill_data;
   logic [DW-1:0]     depth_q, depth_d;
   logic [AW:0]       sp_q, sp_d;   // count of RAM-resident entries
   logic              ovf_q, udf_q;
   logic              accept, spill, refill, ovf_hit, udf_hit;
   logic [AW-1:0]     rd_addr;

   tos_depth_ctrl #(.CAP(CAP)) u_depth (
      .op      (op),
      .depth_q (depth_q),
      .accept  (accept),
      .spill   (spill),
      .refill  (refill),
      .ovf_hit (ovf_hit),
      .udf_hit (udf_hit),
      .depth_d (depth_d)
   );

   tos_alu #(.WIDTH(DATA_W)) u_alu (
      .op  (op),
      .lhs (b_q),
      .rhs (a_q),
      .res (alu_res)
   );

   always_comb begin
      sp_d = sp_q;
      if (spill) begin
         sp_d = sp_q + 1'b1;
      end else if (refill) begin
         sp_d = sp_q - 1'b1;
      end
      // aim the read port at the newest entry as it will be after this edge
      rd_addr = (sp_d == '0) ? '0 : AW'(sp_d - 1'b1);
   end

   tos_stack_ram #(.WIDTH(DATA_W), .SLOTS(RAM_DEPTH)) u_ram (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (spill),
      .wr_addr (sp_q[AW-1:0]),
      .wr_data (b_q),
      .rd_addr (rd_addr),
      .rd_data (refill_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q     <= '0;
         b_q     <= '0;
         depth_q <= '0;
         sp_q    <= '0;
         ovf_q   <= 1'b0;
         udf_q   <= 1'b0;
      end else begin
         depth_q <= depth_d;
         sp_q    <= sp_d;
         if (ovf_hit) ovf_q <= 1'b1;
         if (udf_hit) udf_q <= 1'b1;
         if (accept) begin
            if (op == OP_PUSH) begin
               a_q <= lit;
               b_q <= a_q;
            end else begin
               a_q <= (op == OP_POP) ? b_q : alu_res;
               b_q <= refill ? refill_data : '0;
            end
         end
      end
   end

   assign tos       = a_q;
   assign nos       = b_q;
   assign depth     = depth_q;
   assign overflow  = ovf_q;
   assign underflow = udf_q;

endmodule

// File: rtl/tos_cache_stack_chk.sv
module tos_cache_stack_chk #(
   parameter int DATA_W    = 32,
   parameter int RAM_DEPTH = 64,
   localparam int CAP = RAM_DEPTH + 2,
   localparam int DW  = $clog2(CAP + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        cmd,
   input logic [DATA_W-1:0] lit,
   input logic [DATA_W-1:0] tos,
   input logic [DATA_W-1:0] nos,
   input logic [DW-1:0]     depth,
   input logic              overflow,
   input logic              underflow
);

   localparam logic [DW-1:0] FULL = DW'(CAP);
   localparam logic [DW-1:0] ONE  = DW'(1);
   localparam logic [DW-1:0] TWO  = DW'(2);

   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (tos == '0 && nos == '0 && depth == '0 && !overflow && !underflow));

   a_r2_push_shift: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b001 && depth < FULL) |=>
         (tos == $past(lit) && nos == $past(tos) && depth == $past(depth) + ONE));

   a_r3_add_result: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b011 && depth >= TWO) |=>
         (tos == $past(nos) + $past(tos) && depth == $past(depth) - ONE));

   a_r3_sub_result: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b100 && depth >= TWO) |=> (tos == $past(nos) - $past(tos)));

   a_r5_pop_moves_nos: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b010 && depth >= ONE) |=>
         (tos == $past(nos) && depth == $past(depth) - ONE));

   a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
      (depth < TWO) |-> (nos == '0 && (depth != '0 || tos == '0)));

   a_r7_nop_holds: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b000) |=> ($stable(tos) && $stable(nos) && $stable(depth) &&
                           $stable(overflow) && $stable(underflow)));

   a_r8_overflow_refused: assert property (@(posedge clk) disable iff (rst)
      (cmd == 3'b001 && depth == FULL) |=>
         (overflow && $stable(tos) && $stable(nos) && $stable(depth)));

   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   a_r9_underflow_refused: assert property (@(posedge clk) disable iff (rst)
      ((cmd == 3'b010 && depth == '0) || (cmd[2:1] != 2'b00 && cmd != 3'b010 && depth < TWO)) |=>
         (underflow && $stable(tos) && $stable(nos) && $stable(depth)));

   a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
      underflow |=> underflow);

   a_r8_depth_bounded: assert property (@(posedge clk) disable iff (rst)
      depth <= FULL);

endmodule

bind tos_cache_stack tos_cache_stack_chk #(
   .DATA_W    (DATA_W),
   .RAM_DEPTH (RAM_DEPTH)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd       (cmd),
   .lit       (lit),
   .tos       (tos),
   .nos       (nos),
   .depth     (depth),
   .overflow  (overflow),
   .underflow (underflow)
);

// File: tb/tos_cache_stack_test.sv
module tos_cache_stack_test;

   localparam int DATA_W    = 32;
   localparam int RAM_DEPTH = 64;
   localparam int CAP       = RAM_DEPTH + 2;
   localparam int DW        = $clog2(CAP + 1);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [2:0]        cmd = 3'b000;
   logic [DATA_W-1:0] lit = '0;
   logic [DATA_W-1:0] tos, nos;
   logic [DW-1:0]     depth;
   logic              overflow, underflow;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [DATA_W-1:0] mdl [$];
   bit exp_ovf, exp_udf;

   always #2 clk = ~clk;

   tos_cache_stack #(.DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH)) uut (
      .clk(clk), .rst(rst), .cmd(cmd), .lit(lit),
      .tos(tos), .nos(nos), .depth(depth),
      .overflow(overflow), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      logic [DATA_W-1:0] et, en;
      int n = mdl.size();
      et = (n >= 1) ? mdl[n-1] : '0;
      en = (n >= 2) ? mdl[n-2] : '0;
      chk(tos == et, tag, "tos", tos, et);
      chk(nos == en, tag, "nos", nos, en);
      chk(int'(depth) == n, tag, "depth", DATA_W'(depth), DATA_W'(n));
      chk(overflow == exp_ovf, tag, "overflow", DATA_W'(overflow), DATA_W'(exp_ovf));
      chk(underflow == exp_udf, tag, "underflow", DATA_W'(underflow), DATA_W'(exp_udf));
   endtask

   function automatic logic [DATA_W-1:0] ref_op(input logic [2:0] c,
         input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
      case (c)
         3'b011:  return x + y;
         3'b100:  return x - y;
         3'b101:  return x & y;
         3'b110:  return x | y;
         default: return x ^ y;
      endcase
   endfunction

   task automatic model_apply(input logic [2:0] c, input logic [DATA_W-1:0] v);
      logic [DATA_W-1:0] x, y;
      if (c == 3'b001) begin
         if (mdl.size() == CAP) exp_ovf = 1'b1;
         else mdl.push_back(v);
      end else if (c == 3'b010) begin
         if (mdl.size() < 1) exp_udf = 1'b1;
         else void'(mdl.pop_back());
      end else if (c != 3'b000) begin
         if (mdl.size() < 2) exp_udf = 1'b1;
         else begin
            y = mdl.pop_back();
            x = mdl.pop_back();
            mdl.push_back(ref_op(c, x, y));
         end
      end
   endtask

   // drive at a falling edge, result is registered on the next rising edge
   task automatic step(input logic [2:0] c, input logic [DATA_W-1:0] v, input string tag);
      cmd = c;
      lit = v;
      @(negedge clk);
      model_apply(c, v);
      check_state(tag);
      cmd = 3'b000;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      cmd = 3'b000;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      mdl.delete();
      exp_ovf = 1'b0;
      exp_udf = 1'b0;
      check_state("R1");
   endtask

   task automatic t_push_basic();
      t_reset();
      step(3'b001, 32'h0000_00A1, "R2");
      step(3'b001, 32'h0000_00B2, "R2");
      step(3'b001, 32'h0000_00C3, "R2");
      step(3'b000, 32'hDEAD_BEEF, "R7");
      step(3'b000, 32'h0, "R7");
   endtask

   task automatic t_alu_ops();
      t_reset();
      step(3'b001, 32'd10, "R2");
      step(3'b001, 32'd3,  "R2");
      step(3'b100, 32'h0,  "R3 sub");
      step(3'b001, 32'd3,  "R2");
      step(3'b001, 32'd10, "R2");
      step(3'b100, 32'h0,  "R3 sub wrap");
      step(3'b001, 32'h0000_F0F0, "R2");
      step(3'b001, 32'h0000_3C3C, "R2");
      step(3'b101, 32'h0,  "R3 and");
      step(3'b001, 32'h1200_0034, "R2");
      step(3'b110, 32'h0,  "R3 or");
      step(3'b001, 32'hFFFF_0000, "R2");
      step(3'b111, 32'h0,  "R3 xor");
      step(3'b001, 32'hFFFF_FFFF, "R2");
      step(3'b011, 32'h0,  "R3 add");
      step(3'b011, 32'h0,  "R3 add");
      step(3'b011, 32'h0,  "R3 add");
      step(3'b010, 32'h0,  "R6");
   endtask

   task automatic t_pop_refill();
      t_reset();
      for (int i = 1; i <= 6; i++) step(3'b001, DATA_W'(i * 17), "R2");
      step(3'b010, 32'h0, "R4 R5");
      step(3'b011, 32'h0, "R4");
      step(3'b010, 32'h0, "R4 R5");
      step(3'b010, 32'h0, "R5");
      step(3'b010, 32'h0, "R6");
      step(3'b010, 32'h0, "R6");
   endtask

   task automatic t_back_to_back();
      t_reset();
      step(3'b001, 32'h1111_1111, "R2");
      step(3'b001, 32'h2222_2222, "R2");
      step(3'b001, 32'h3333_3333, "R2");
      step(3'b010, 32'h0, "R10 pop after spill");
      step(3'b001, 32'h4444_4444, "R2");
      step(3'b011, 32'h0, "R10 add after spill");
      step(3'b001, 32'h5555_5555, "R2");
      step(3'b001, 32'h6666_6666, "R2");
      step(3'b111, 32'h0, "R10 xor after spill");
      step(3'b010, 32'h0, "R4");
      step(3'b010, 32'h0, "R4");
   endtask

   task automatic t_underflow();
      t_reset();
      step(3'b010, 32'h0, "R9 pop empty");
      step(3'b001, 32'h0000_0055, "R2");
      step(3'b011, 32'h0, "R9 add one entry");
      step(3'b100, 32'h0, "R9 sub one entry");
      step(3'b010, 32'h0, "R9 sticky R5");
      step(3'b000, 32'h0, "R9 sticky R7");
   endtask

   task automatic t_overflow();
      t_reset();
      for (int i = 0; i < CAP; i++) step(3'b001, DATA_W'(32'hA000_0000 + i), "R2 fill");
      step(3'b001, 32'hBAD0_BAD0, "R8 push full");
      step(3'b001, 32'hBAD1_BAD1, "R8 push full again");
      for (int i = 0; i < CAP; i++) step(3'b010, 32'h0, "R4 R8 drain");
      step(3'b000, 32'h0, "R8 sticky");
   endtask

   initial begin
      t_push_basic();
      t_alu_ops();
      t_pop_refill();
      t_back_to_back();
      t_underflow();
      t_overflow();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule